// File: doc/BRIEF.md
# In-DRAM Bulk Operation Sequencer

This block sits in front of a DRAM command scheduler and turns one high-level bulk request into a short burst of row commands whose spacing is deliberately tighter than normal timing. It relies on two effects. Opening a second row while the bitlines still carry the first row's data writes that data into the second row. Opening three rows at once makes each bitline settle to the majority of the three cells. With one of the three rows held at all zeros, the result is a bulk AND. With it held at all ones, the result is a bulk OR.

A request carries an operation code, two source rows, three scratch ("compute") rows, the addresses of an all-zeros row and an all-ones row, and a list of up to `MAX_DST` destination rows with a count. For AND and OR, the block first copies each operand and the matching constant row into the scratch rows, so the originals survive the destructive majority step. It then fires the triple activation and writes the result into every listed destination before closing the bank. Two wait values, sampled when the request is accepted, set the number of idle cycles after an activation and after a precharge. A single-cycle `done` marks the end of each request.

Top module: `bulk_op_seq`

## Requirements
- R1: While reset is held and right after it is released, `reqReady` is 1, `cmdValid` is 0, `cmdCode` is NOP (0), all command rows are 0, and `done` and `err` are 0.
- R2: A request is accepted in a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the next cycle until the cycle in which `done` pulses high for exactly one cycle, and `reqReady` is 1 again in that same cycle. All request fields and both wait values are captured at acceptance, so later changes to them have no effect on the operation.
- R3: Opcode 0 (copy) issues ACT source-A, then ACT on destination entry 0, then PRE. Only entry 0 is used, even when the count is larger than 1.
- R4: Opcode 1 (multi-copy) issues ACT source-A, then ACT on destination entries 0 to count-1 in order, then a single PRE.
- R5: Opcode 2 (AND) issues ACT srcA, ACT tmpA, PRE, ACT srcB, ACT tmpB, PRE, ACT zero-row, ACT tmpC, PRE, then one ACT3 over tmpA/tmpB/tmpC. It then issues ACT on each destination entry 0 to count-1 and a final PRE.
- R6: Opcode 3 (OR) follows the same sequence as R5, except that the all-ones row replaces the all-zeros row.
- R7: The first command appears two cycles after the acceptance cycle. After an ACT or ACT3 strobe, exactly `cfgActGap` idle cycles pass before the next command. After a PRE strobe, exactly `cfgPreWait` idle cycles pass before the next command. When that PRE is the last command, the same wait passes before `done`.
- R8: A count of 0, or a count above `MAX_DST`, is illegal. No command is issued, and `done` and `err` are both 1 two cycles after the acceptance cycle. For legal requests, `err` is 0 with `done`.
- R9: Command codes are NOP=0, ACT=1, ACT3=2 and PRE=3. `cmdValid` is a one-cycle strobe, and every non-NOP code comes with it. ACT puts its row on `cmdRowA`. ACT3 puts tmpA/tmpB/tmpC on rows A/B/C. Every row field not used by the command is 0, and PRE carries all rows 0.
- R10: Destination entry i sits at bits [i*ROW_W +: ROW_W] of `reqDstList`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqOp | input | 2 | 0 copy, 1 multi-copy, 2 AND, 3 OR |
| reqSrcA | input | ROW_W | First source row |
| reqSrcB | input | ROW_W | Second operand row (AND/OR) |
| reqDstCount | input | CNT_W | Number of valid destination entries |
| reqDstList | input | MAX_DST*ROW_W | Packed destination rows |
| reqZeroRow | input | ROW_W | Row preloaded with all zeros |
| reqOneRow | input | ROW_W | Row preloaded with all ones |
| reqTmpA | input | ROW_W | Scratch row for operand A |
| reqTmpB | input | ROW_W | Scratch row for operand B |
| reqTmpC | input | ROW_W | Scratch row for the constant |
| cfgActGap | input | WAIT_W | Idle cycles after an activation |
| cfgPreWait | input | WAIT_W | Idle cycles after a precharge |
| cmdValid | output | 1 | Command strobe |
| cmdCode | output | 2 | Command code |
| cmdRowA | output | ROW_W | First row address |
| cmdRowB | output | ROW_W | Second row address (ACT3) |
| cmdRowC | output | ROW_W | Third row address (ACT3) |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request was illegal (valid with done) |

## Verification
All four opcodes are swept over every legal destination count, against several activation gaps and precharge waits, including zero gaps. This separates the single-destination copy from the multi-copy. It also shows whether the constant row follows the opcode, and whether each wait counter is applied after the right kind of command. Every command is compared on code, all three rows and exact cycle. Request fields and wait values are scrambled right after acceptance, which exposes any late sampling. Zero and over-range counts check the error path and confirm that no command leaks onto the bus.

// File: rtl/bulk_seq_pkg.sv
package bulk_seq_pkg;

  typedef enum logic [1:0] {
    OP_COPY  = 2'd0,
    OP_MCOPY = 2'd1,
    OP_AND   = 2'd2,
    OP_OR    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_ACT3 = 2'd2,
    CMD_PRE  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SRCA,
    SEL_SRCB,
    SEL_CONST,
    SEL_TMPA,
    SEL_TMPB,
    SEL_TMPC,
    SEL_DST
  } rowsel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } state_e;

  typedef enum logic [1:0] {
    PH_STAGE,
    PH_OPEN,
    PH_DEST,
    PH_CLOSE
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    illegal;
    logic    fire;
    cmd_e    code;
    rowsel_e sel;
    logic    finish;
  } strobe_t;

endpackage

// File: rtl/bulk_seq_dp.sv
module bulk_seq_dp
  import bulk_seq_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int MAX_DST = 8,
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [IDX_W-1:0]         dstIdx,
  input  logic [1:0]               reqOp,
  input  logic [ROW_W-1:0]         reqSrcA,
  input  logic [ROW_W-1:0]         reqSrcB,
  input  logic [CNT_W-1:0]         reqDstCount,
  input  logic [MAX_DST*ROW_W-1:0] reqDstList,
  input  logic [ROW_W-1:0]         reqZeroRow,
  input  logic [ROW_W-1:0]         reqOneRow,
  input  logic [ROW_W-1:0]         reqTmpA,
  input  logic [ROW_W-1:0]         reqTmpB,
  input  logic [ROW_W-1:0]         reqTmpC,
  input  logic [WAIT_W-1:0]        cfgActGap,
  input  logic [WAIT_W-1:0]        cfgPreWait,
  output op_e                      opQ,
  output logic [CNT_W-1:0]         countQ,
  output logic [WAIT_W-1:0]        actGapQ,
  output logic [WAIT_W-1:0]        preWaitQ,
  output logic                     cmdValid,
  output logic [1:0]               cmdCode,
  output logic [ROW_W-1:0]         cmdRowA,
  output logic [ROW_W-1:0]         cmdRowB,
  output logic [ROW_W-1:0]         cmdRowC,
  output logic                     done,
  output logic                     err
);

  logic [ROW_W-1:0] srcAQ, srcBQ, zeroQ, oneQ, tmpAQ, tmpBQ, tmpCQ;
  logic [ROW_W-1:0] dstQ [MAX_DST];
  logic             errQ;
  logic [ROW_W-1:0] rowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ      <= OP_COPY;
      countQ   <= '0;
      actGapQ  <= '0;
      preWaitQ <= '0;
      srcAQ    <= '0;
      srcBQ    <= '0;
      zeroQ    <= '0;
      oneQ     <= '0;
      tmpAQ    <= '0;
      tmpBQ    <= '0;
      tmpCQ    <= '0;
      errQ     <= 1'b0;
    end else if (stb.capture) begin
      opQ      <= op_e'(reqOp);
      countQ   <= reqDstCount;
      actGapQ  <= cfgActGap;
      preWaitQ <= cfgPreWait;
      srcAQ    <= reqSrcA;
      srcBQ    <= reqSrcB;
      zeroQ    <= reqZeroRow;
      oneQ     <= reqOneRow;
      tmpAQ    <= reqTmpA;
      tmpBQ    <= reqTmpB;
      tmpCQ    <= reqTmpC;
      errQ     <= stb.illegal;
    end
  end

  for (genvar g = 0; g < MAX_DST; g++) begin : g_dst
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            dstQ[g] <= '0;
      else if (stb.capture) dstQ[g] <= reqDstList[g*ROW_W +: ROW_W];
    end
  end

  always_comb begin
    unique case (stb.sel)
      SEL_SRCA:  rowSel = srcAQ;
      SEL_SRCB:  rowSel = srcBQ;
      SEL_CONST: rowSel = (opQ == OP_OR) ? oneQ : zeroQ;
      SEL_TMPA:  rowSel = tmpAQ;
      SEL_TMPB:  rowSel = tmpBQ;
      SEL_TMPC:  rowSel = tmpCQ;
      SEL_DST:   rowSel = dstQ[dstIdx];
      default:   rowSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCode  <= CMD_NOP;
      cmdRowA  <= '0;
      cmdRowB  <= '0;
      cmdRowC  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      cmdValid <= stb.fire;
      cmdCode  <= stb.fire ? stb.code : CMD_NOP;
      cmdRowA  <= stb.fire ? rowSel : '0;
      cmdRowB  <= (stb.fire && stb.code == CMD_ACT3) ? tmpBQ : '0;
      cmdRowC  <= (stb.fire && stb.code == CMD_ACT3) ? tmpCQ : '0;
      done     <= stb.finish;
      err      <= stb.finish & errQ;
    end
  end

endmodule

// File: rtl/bulk_seq_ctrl.sv
module bulk_seq_ctrl
  import bulk_seq_pkg::*;
#(
  parameter int MAX_DST = 8,
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [CNT_W-1:0]  reqDstCount,
  input  op_e               opQ,
  input  logic [CNT_W-1:0]  countQ,
  input  logic [WAIT_W-1:0] actGapQ,
  input  logic [WAIT_W-1:0] preWaitQ,
  output logic              reqReady,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  dstIdx
);

  localparam int STAGE_LAST = 8;

  state_e            state;
  phase_e            phase;
  logic [3:0]        step;
  logic [WAIT_W-1:0] waitCnt;
  logic              closing;
  logic              accept, illegal, isLogic, lastDest;
  logic [WAIT_W-1:0] gapSel;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign illegal  = (reqDstCount == '0) || (reqDstCount > CNT_W'(MAX_DST));
  assign isLogic  = (opQ == OP_AND) || (opQ == OP_OR);
  assign lastDest = (opQ == OP_COPY) || (CNT_W'(dstIdx) == countQ - CNT_W'(1));

  always_comb begin
    stb         = '0;
    stb.code    = CMD_NOP;
    stb.sel     = SEL_NONE;
    stb.capture = accept;
    stb.illegal = illegal;
    stb.finish  = (state == ST_FINISH);
    if (state == ST_ISSUE) begin
      stb.fire = 1'b1;
      unique case (phase)
        PH_STAGE: begin
          stb.code = CMD_ACT;
          unique case (step)
            4'd0:    stb.sel = SEL_SRCA;
            4'd1:    stb.sel = SEL_TMPA;
            4'd3:    stb.sel = SEL_SRCB;
            4'd4:    stb.sel = SEL_TMPB;
            4'd6:    stb.sel = SEL_CONST;
            4'd7:    stb.sel = SEL_TMPC;
            default: stb.code = CMD_PRE;
          endcase
        end
        PH_OPEN: begin
          stb.code = isLogic ? CMD_ACT3 : CMD_ACT;
          stb.sel  = isLogic ? SEL_TMPA : SEL_SRCA;
        end
        PH_DEST: begin
          stb.code = CMD_ACT;
          stb.sel  = SEL_DST;
        end
        default: stb.code = CMD_PRE;
      endcase
    end
  end

  assign gapSel = (stb.code == CMD_PRE) ? preWaitQ : actGapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_STAGE;
      step    <= '0;
      dstIdx  <= '0;
      waitCnt <= '0;
      closing <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= illegal ? ST_FINISH : ST_ISSUE;
          phase  <= reqOp[1] ? PH_STAGE : PH_OPEN;
          step   <= '0;
          dstIdx <= '0;
        end
        ST_ISSUE: begin
          closing <= (phase == PH_CLOSE);
          if (gapSel == '0) begin
            state <= (phase == PH_CLOSE) ? ST_FINISH : ST_ISSUE;
          end else begin
            state   <= ST_WAIT;
            waitCnt <= gapSel;
          end
          unique case (phase)
            PH_STAGE: if (step == 4'(STAGE_LAST)) phase <= PH_OPEN;
                      else step <= step + 4'd1;
            PH_OPEN:  begin phase <= PH_DEST; dstIdx <= '0; end
            PH_DEST:  if (lastDest) phase <= PH_CLOSE;
                      else dstIdx <= dstIdx + IDX_W'(1);
            default:  ;
          endcase
        end
        ST_WAIT: begin
          if (waitCnt == WAIT_W'(1)) state <= closing ? ST_FINISH : ST_ISSUE;
          waitCnt <= waitCnt - WAIT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bulk_op_seq.sv
module bulk_op_seq
  import bulk_seq_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int MAX_DST = 8,
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = $clog2(MAX_DST + 1),
  localparam int IDX_W  = (MAX_DST > 1) ? $clog2(MAX_DST) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [1:0]               reqOp,
  input  logic [ROW_W-1:0]         reqSrcA,
  input  logic [ROW_W-1:0]         reqSrcB,
  input  logic [CNT_W-1:0]         reqDstCount,
  input  logic [MAX_DST*ROW_W-1:0] reqDstList,
  input  logic [ROW_W-1:0]         reqZeroRow,
  input  logic [ROW_W-1:0]         reqOneRow,
  input  logic [ROW_W-1:0]         reqTmpA,
  input  logic [ROW_W-1:0]         reqTmpB,
  input  logic [ROW_W-1:0]         reqTmpC,
  input  logic [WAIT_W-1:0]        cfgActGap,
  input  logic [WAIT_W-1:0]        cfgPreWait,
  output logic                     cmdValid,
  output logic [1:0]               cmdCode,
  output logic [ROW_W-1:0]         cmdRowA,
  output logic [ROW_W-1:0]         cmdRowB,
  output logic [ROW_W-1:0]         cmdRowC,
  output logic                     done,
  output logic                     err
);

  strobe_t           stb;
  logic [IDX_W-1:0]  dstIdx;
  op_e               opQ;
  logic [CNT_W-1:0]  countQ;
  logic [WAIT_W-1:0] actGapQ, preWaitQ;

  bulk_seq_ctrl #(
    .MAX_DST(MAX_DST), .WAIT_W(WAIT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqDstCount(reqDstCount), .opQ(opQ), .countQ(countQ),
    .actGapQ(actGapQ), .preWaitQ(preWaitQ), .reqReady(reqReady),
    .stb(stb), .dstIdx(dstIdx)
  );

  bulk_seq_dp #(
    .ROW_W(ROW_W), .MAX_DST(MAX_DST), .WAIT_W(WAIT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dstIdx(dstIdx), .reqOp(reqOp),
    .reqSrcA(reqSrcA), .reqSrcB(reqSrcB), .reqDstCount(reqDstCount),
    .reqDstList(reqDstList), .reqZeroRow(reqZeroRow), .reqOneRow(reqOneRow),
    .reqTmpA(reqTmpA), .reqTmpB(reqTmpB), .reqTmpC(reqTmpC),
    .cfgActGap(cfgActGap), .cfgPreWait(cfgPreWait), .opQ(opQ), .countQ(countQ),
    .actGapQ(actGapQ), .preWaitQ(preWaitQ), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdRowA(cmdRowA), .cmdRowB(cmdRowB), .cmdRowC(cmdRowC),
    .done(done), .err(err)
  );

endmodule

// File: rtl/bulk_seq_chk.sv
module bulk_seq_chk #(
  parameter int ROW_W   = 16,
  parameter int MAX_DST = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [CNT_W-1:0] reqDstCount,
  input logic             cmdValid,
  input logic [1:0]       cmdCode,
  input logic [ROW_W-1:0] cmdRowA,
  input logic [ROW_W-1:0] cmdRowB,
  input logic [ROW_W-1:0] cmdRowC,
  input logic             done,
  input logic             err
);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid);

  // R9
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmdCode == 2'd0 && cmdRowA == '0 && cmdRowB == '0 && cmdRowC == '0));

  // R9
  strobe_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode != 2'd0));

  // R9
  pre_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 2'd3) |-> (cmdRowA == '0 && cmdRowB == '0 && cmdRowC == '0));

  // R8
  illegal_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqDstCount == '0 || reqDstCount > CNT_W'(MAX_DST)))
      |-> ##1 !cmdValid ##1 (done && err && !cmdValid));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

endmodule

bind bulk_op_seq bulk_seq_chk #(
  .ROW_W(ROW_W), .MAX_DST(MAX_DST), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqDstCount(reqDstCount), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdRowA(cmdRowA), .cmdRowB(cmdRowB), .cmdRowC(cmdRowC),
  .done(done), .err(err)
);

// File: tb/tb_bulk_op_seq.sv
module tb_bulk_op_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W   = 16;
  localparam int MAX_DST = 8;
  localparam int WAIT_W  = 8;
  localparam int CNT_W   = 4;
  localparam int LOG_MAX = 64;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     reqValid = 1'b0;
  logic                     reqReady;
  logic [1:0]               reqOp = '0;
  logic [ROW_W-1:0]         reqSrcA = '0, reqSrcB = '0, reqZeroRow = '0, reqOneRow = '0;
  logic [ROW_W-1:0]         reqTmpA = '0, reqTmpB = '0, reqTmpC = '0;
  logic [CNT_W-1:0]         reqDstCount = '0;
  logic [MAX_DST*ROW_W-1:0] reqDstList = '0;
  logic [WAIT_W-1:0]        cfgActGap = '0, cfgPreWait = '0;
  logic                     cmdValid, done, err;
  logic [1:0]               cmdCode;
  logic [ROW_W-1:0]         cmdRowA, cmdRowB, cmdRowC;

  bulk_op_seq #(.ROW_W(ROW_W), .MAX_DST(MAX_DST), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqSrcA(reqSrcA), .reqSrcB(reqSrcB), .reqDstCount(reqDstCount),
    .reqDstList(reqDstList), .reqZeroRow(reqZeroRow), .reqOneRow(reqOneRow),
    .reqTmpA(reqTmpA), .reqTmpB(reqTmpB), .reqTmpC(reqTmpC),
    .cfgActGap(cfgActGap), .cfgPreWait(cfgPreWait), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdRowA(cmdRowA), .cmdRowB(cmdRowB), .cmdRowC(cmdRowC),
    .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nErrors = 0;

  // monitor of the command bus
  int logCode [LOG_MAX];
  int logA [LOG_MAX];
  int logB [LOG_MAX];
  int logC [LOG_MAX];
  int logCyc [LOG_MAX];
  int nLog = 0;
  int doneCyc = -1;
  int doneErr = 0;
  int doneRdy = 0;
  bit seenDone = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid) begin
        if (nLog < LOG_MAX) begin
          logCode[nLog] = int'(cmdCode);
          logA[nLog] = int'(cmdRowA);
          logB[nLog] = int'(cmdRowB);
          logC[nLog] = int'(cmdRowC);
          logCyc[nLog] = cyc;
        end
        nLog++;
      end
      if (done && !seenDone) begin
        seenDone = 1'b1;
        doneCyc = cyc;
        doneErr = int'(err);
        doneRdy = int'(reqReady);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected command list
  int eCode [LOG_MAX];
  int eA [LOG_MAX];
  int eB [LOG_MAX];
  int eC [LOG_MAX];
  int eCyc [LOG_MAX];
  int nExp;

  task automatic pushCmd(input int code, input int a, input int b, input int c);
    eCode[nExp] = code; eA[nExp] = a; eB[nExp] = b; eC[nExp] = c;
    nExp++;
  endtask

  task automatic runOp(input int op, input int cnt, input int ag, input int pw, input int base);
    int a, c, waitN, dstUsed;
    string req;
    bit legal;
    legal = (cnt >= 1) && (cnt <= MAX_DST);
    req = !legal ? "R8" : (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R6";
    @(negedge clk);
    waitN = 0;
    while (!reqReady && waitN < 2000) begin @(negedge clk); waitN++; end
    nLog = 0; seenDone = 1'b0; doneCyc = -1;
    reqOp = 2'(op);
    reqSrcA = ROW_W'(base + 1); reqSrcB = ROW_W'(base + 2);
    reqZeroRow = ROW_W'(base + 3); reqOneRow = ROW_W'(base + 4);
    reqTmpA = ROW_W'(base + 5); reqTmpB = ROW_W'(base + 6); reqTmpC = ROW_W'(base + 7);
    reqDstCount = CNT_W'(cnt);
    for (int i = 0; i < MAX_DST; i++) reqDstList[i*ROW_W +: ROW_W] = ROW_W'(base + 16 + i); // R10
    cfgActGap = WAIT_W'(ag); cfgPreWait = WAIT_W'(pw);
    reqValid = 1'b1;
    a = cyc;
    @(negedge clk);
    check(reqReady == 1'b0, "R2", "ready after accept", int'(reqReady), 0);
    reqValid = 1'b0;
    // R2: scramble everything after acceptance
    reqOp = ~reqOp; reqSrcA = ~reqSrcA; reqSrcB = ~reqSrcB; reqZeroRow = ~reqZeroRow;
    reqOneRow = ~reqOneRow; reqTmpA = ~reqTmpA; reqTmpB = ~reqTmpB; reqTmpC = ~reqTmpC;
    reqDstList = ~reqDstList; reqDstCount = ~reqDstCount;
    cfgActGap = WAIT_W'(ag + 5); cfgPreWait = WAIT_W'(pw + 3);
    waitN = 0;
    while (!seenDone && waitN < 2000) begin @(negedge clk); waitN++; end
    @(negedge clk);
    check(seenDone, req, "done seen", int'(seenDone), 1);

    nExp = 0;
    if (legal) begin
      if (op >= 2) begin
        pushCmd(1, base + 1, 0, 0); pushCmd(1, base + 5, 0, 0); pushCmd(3, 0, 0, 0);
        pushCmd(1, base + 2, 0, 0); pushCmd(1, base + 6, 0, 0); pushCmd(3, 0, 0, 0);
        pushCmd(1, (op == 3) ? base + 4 : base + 3, 0, 0); pushCmd(1, base + 7, 0, 0);
        pushCmd(3, 0, 0, 0);
        pushCmd(2, base + 5, base + 6, base + 7);
      end else begin
        pushCmd(1, base + 1, 0, 0);
      end
      dstUsed = (op == 0) ? 1 : cnt;
      for (int i = 0; i < dstUsed; i++) pushCmd(1, base + 16 + i, 0, 0);
      pushCmd(3, 0, 0, 0);
      c = a + 2;
      for (int j = 0; j < nExp; j++) begin
        eCyc[j] = c;
        c += ((eCode[j] == 3) ? pw : ag) + 1;
      end
      check(doneCyc == c, "R7", "done cycle", doneCyc - a, c - a);
      check(doneErr == 0, "R8", "err on legal", doneErr, 0);
    end else begin
      check(doneCyc == a + 2, "R8", "illegal done cycle", doneCyc - a, 2);
      check(doneErr == 1, "R8", "illegal err", doneErr, 1);
    end
    check(doneRdy == 1, "R2", "ready with done", doneRdy, 1);
    check(nLog == nExp, req, "command count", nLog, nExp);
    if (nLog == nExp) begin
      for (int j = 0; j < nExp; j++) begin
        check(logCode[j] == eCode[j], req, "code", logCode[j], eCode[j]);
        check(logA[j] == eA[j], req, "rowA", logA[j], eA[j]);
        check(logB[j] == eB[j] && logC[j] == eC[j], "R9", "rowB/rowC",
              logB[j] * 65536 + logC[j], eB[j] * 65536 + eC[j]);
        check(logCyc[j] == eCyc[j], "R7", "command cycle", logCyc[j] - a, eCyc[j] - a);
      end
    end
  endtask

  initial begin
    int trial;
    int agSet [3];
    int pwSet [2];
    agSet = '{0, 1, 3};
    pwSet = '{0, 2};
    trial = 0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !cmdValid && cmdCode == 2'd0 && !done && !err, "R1", "post-reset outputs",
          int'({reqReady, cmdValid, cmdCode, done, err}), 32);
    check(cmdRowA == '0 && cmdRowB == '0 && cmdRowC == '0, "R1", "post-reset rows",
          int'(cmdRowA | cmdRowB | cmdRowC), 0);
    for (int op = 0; op < 4; op++)
      for (int cnt = 1; cnt <= MAX_DST; cnt++)
        for (int gi = 0; gi < 3; gi++)
          for (int pi = 0; pi < 2; pi++) begin
            runOp(op, cnt, agSet[gi], pwSet[pi], (trial * 40) % 30000);
            trial++;
          end
    runOp(2, 0, 1, 1, 500);
    for (int cnt = MAX_DST + 1; cnt < 16; cnt++) runOp(cnt % 4, cnt, 0, 0, 600 + cnt * 40);
    runOp(1, 3, 2, 1, 1000);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule